// File: doc/BRIEF.md
# Four-Output Aligned PWM Group

This block generates four pulse-width-modulated outputs from one shared period counter. It is meant for switching stages in motor drives or class-D audio power stages. The counter runs either as a sawtooth, which gives edge-aligned pulses, or as a triangle, which gives center-aligned pulses. The outputs form two pairs. In paired mode each pair drives a true output and its exact complement, and both come from one duty value. In non-paired mode every output compares against its own duty value.

Software writes the period, the mode and the four duty values into shadow registers through a simple write port. The block copies the shadow values into the active registers only at defined points. Every active register is reloaded at the start of each period. In center-aligned double-update mode, the duty registers are also reloaded at the turning point of the triangle, so the rising half and the falling half of a period may use different duty values. A one-cycle sync pulse marks each period start.

Register addresses for `NUM_PAIRS = 2`:
- 0 holds the period.
- 1 holds the mode: bit 0 selects center alignment, bit 1 selects paired mode, bit 2 selects double update.
- 4 to 7 hold the duty values of outputs 0 to 3.

Top module: `pwm_quad_group`

## Requirements
- R1: After reset, and whenever the active period is 0, the block is idle. All outputs and the sync pulse are low, the counter rests at 0, and every shadow register is copied into its active register at every clock edge.
- R2: With mode bit 0 clear (edge-aligned), the counter steps 0, 1, …, P-1 and wraps. One period therefore lasts P cycles.
- R3: With mode bit 0 set (center-aligned), the counter steps up 0 … P-1, holds P-1 for one more cycle while counting down, and then steps down to 0. One period therefore lasts 2P cycles. With a fixed duty D ≤ P, an output is high for 2D cycles, placed symmetrically about the period boundary.
- R4: With mode bit 1 clear (non-paired), output n is high exactly while the counter is below the duty value written at address 4+n.
- R5: With mode bit 1 set (paired), output 0 compares against duty 0 and output 1 is its complement. Output 2 compares against duty 2 and output 3 is its complement. Duty 1 and duty 3 have no effect.
- R6: A duty value of 0 keeps its output low for the whole period. A duty value at or above P keeps it high for the whole period.
- R7: Duty writes do not take effect until the next period start. The exception is R8.
- R8: With mode bits 0 and 2 both set, the duty shadows are also copied at the turning point. The falling half of the period then uses the values written during the rising half.
- R9: The sync pulse is high for exactly one cycle per period, in the first cycle of each period (counter 0, counting up).
- R10: A write to the period or to the mode register takes effect only at the next period start, never in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | CW (16) | Write data |
| pwm_out | output | 2*NUM_PAIRS (4) | PWM outputs |
| sync_pulse | output | 1 | High in the first cycle of each period |

## Verification
A write lands in a shadow register at the clock edge where `wr_en` is sampled. A copy into the active registers happens at a later edge. The outputs and the sync pulse are combinational from the counter and the active registers, so they change in the same cycle that follows that edge.

While idle, a period write is sampled at one edge, copied at the next edge, and the first sync cycle follows that second edge. The bench advances a cycle-level reference model at each rising edge and compares outputs at the following falling edge. Directed checks first align to an observed sync cycle and then count high cycles over exactly one period, either P or 2P cycles. Writes in those checks are issued in the first cycle after the start, so the edge that samples them is known.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

  typedef struct packed {
    logic dbl;
    logic paired;
    logic center;
  } pwm_mode_t;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    load_start,
  input  logic                    load_mid,
  output logic [CW-1:0]           per_act,
  output pwm_mode_t               mode_act,
  output logic [NCH-1:0][CW-1:0]  duty_act
);

  localparam logic [AW-1:0] A_PER  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);

  logic [CW-1:0]          per_sh_q, per_sh_d, per_act_d;
  pwm_mode_t              mode_sh_q, mode_sh_d, mode_act_d;
  logic [NCH-1:0][CW-1:0] duty_sh_q, duty_sh_d, duty_act_d;

  always_comb begin
    per_sh_d   = per_sh_q;
    mode_sh_d  = mode_sh_q;
    per_act_d  = per_act;
    mode_act_d = mode_act;
    if (wr_en && wr_addr == A_PER)  per_sh_d  = wr_data;
    if (wr_en && wr_addr == A_MODE) mode_sh_d = pwm_mode_t'(wr_data[MODE_W-1:0]);
    if (load_start) begin
      per_act_d  = per_sh_q;
      mode_act_d = mode_sh_q;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_duty
    localparam logic [AW-1:0] A_DUTY = AW'(NCH + n);
    always_comb begin
      duty_sh_d[n]  = duty_sh_q[n];
      duty_act_d[n] = duty_act[n];
      if (wr_en && wr_addr == A_DUTY) duty_sh_d[n]  = wr_data;
      if (load_start || load_mid)     duty_act_d[n] = duty_sh_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q  <= '0;
      mode_sh_q <= '0;
      duty_sh_q <= '0;
      per_act   <= '0;
      mode_act  <= '0;
      duty_act  <= '0;
    end else begin
      per_sh_q  <= per_sh_d;
      mode_sh_q <= mode_sh_d;
      duty_sh_q <= duty_sh_d;
      per_act   <= per_act_d;
      mode_act  <= mode_act_d;
      duty_act  <= duty_act_d;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_act,
  input  logic          center,
  input  logic          dbl,
  output logic [CW-1:0] cnt_q,
  output logic          down_q,
  output logic          idle,
  output logic          load_start,
  output logic          load_mid
);

  logic [CW-1:0] top_val;
  logic          wrap, turn;
  logic [CW-1:0] cnt_d;
  logic          down_d;

  assign idle    = (per_act == '0);
  assign top_val = per_act - CW'(1);

  always_comb begin
    wrap       = center ? (down_q && cnt_q == '0) : (cnt_q == top_val);
    turn       = center && !down_q && !idle && (cnt_q == top_val);
    load_start = idle || wrap;
    load_mid   = turn && dbl;
    cnt_d      = cnt_q;
    down_d     = down_q;
    if (load_start) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (turn) begin
      down_d = 1'b1;
    end else if (down_q) begin
      cnt_d = cnt_q - CW'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int unsigned CW        = 16,
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned NCH      = 2 * NUM_PAIRS
) (
  input  logic [CW-1:0]          cnt_q,
  input  logic                   down_q,
  input  logic                   idle,
  input  logic                   paired,
  input  logic [NCH-1:0][CW-1:0] duty_act,
  output logic [NCH-1:0]         pwm_out,
  output logic                   sync_pulse
);

  logic [NCH-1:0] below;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign below[2*p]   = cnt_q < duty_act[2*p];
    assign below[2*p+1] = cnt_q < duty_act[2*p+1];
    always_comb begin
      pwm_out[2*p]   = !idle && below[2*p];
      pwm_out[2*p+1] = !idle && (paired ? !below[2*p] : below[2*p+1]);
    end
  end

  assign sync_pulse = !idle && !down_q && (cnt_q == '0);

endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
  import pwm_grp_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned NUM_PAIRS = 2,
  localparam int unsigned NCH      = 2 * NUM_PAIRS,
  localparam int unsigned AW       = $clog2(NCH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out,
  output logic           sync_pulse
);

  logic [CW-1:0]          per_act;
  pwm_mode_t              mode_act;
  logic [NCH-1:0][CW-1:0] duty_act;
  logic [CW-1:0]          cnt_q;
  logic                   down_q, idle, load_start, load_mid;

  pwm_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_start(load_start), .load_mid(load_mid),
    .per_act(per_act), .mode_act(mode_act), .duty_act(duty_act)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_act(per_act),
    .center(mode_act.center), .dbl(mode_act.dbl),
    .cnt_q(cnt_q), .down_q(down_q), .idle(idle),
    .load_start(load_start), .load_mid(load_mid)
  );

  pwm_outstage #(.CW(CW), .NUM_PAIRS(NUM_PAIRS)) u_out (
    .cnt_q(cnt_q), .down_q(down_q), .idle(idle), .paired(mode_act.paired),
    .duty_act(duty_act), .pwm_out(pwm_out), .sync_pulse(sync_pulse)
  );

endmodule

// File: rtl/pwm_quad_group_chk.sv
module pwm_quad_group_chk #(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pwm_out,
  input logic           sync_pulse,
  input logic [CW-1:0]  cnt_q,
  input logic [CW-1:0]  per_act,
  input logic           center,
  input logic           paired
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act == '0) |-> (pwm_out == '0 && !sync_pulse));

  // R2
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!center && per_act != '0 && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CW'(1)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt_q < per_act));

  // R5
  pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && per_act != '0) |-> (pwm_out[1] != pwm_out[0] && pwm_out[3] != pwm_out[2]));

  // R9
  sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && (center || per_act > CW'(1))) |=> !sync_pulse);

  // R10
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0 && !sync_pulse) |-> $stable(per_act));

endmodule

bind pwm_quad_group pwm_quad_group_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .sync_pulse(sync_pulse),
  .cnt_q(cnt_q), .per_act(per_act), .center(mode_act.center),
  .paired(mode_act.paired)
);

// File: tb/sim_pwm_quad_group.sv
`timescale 1ns/1ps
module sim_pwm_quad_group;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  pwm_out;
  logic        sync_pulse;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_quad_group u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .sync_pulse(sync_pulse)
  );

  // reference model state
  logic [15:0] sh_per, a_per, m_cnt;
  logic [2:0]  sh_mode, a_mode;
  logic [15:0] sh_duty [4];
  logic [15:0] a_duty [4];
  logic        m_down;
  int          hi_cnt [4];
  int          sync_cnt;

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] model_out();
    logic [3:0] below;
    logic [3:0] o;
    logic       s;
    for (int i = 0; i < 4; i++) below[i] = m_cnt < a_duty[i];
    o = below;
    if (a_mode[1]) begin
      o[1] = !below[0];
      o[3] = !below[2];
    end
    s = !m_down && m_cnt == 0;
    if (a_per == 0) begin
      o = 4'b0;
      s = 1'b0;
    end
    return {s, o};
  endfunction

  task automatic model_step(bit we, logic [2:0] a, logic [15:0] d);
    bit idle, wrap, turn, ls, lm;
    idle = (a_per == 0);
    wrap = a_mode[0] ? (m_down && m_cnt == 0) : (m_cnt == a_per - 16'd1);
    turn = a_mode[0] && !m_down && !idle && (m_cnt == a_per - 16'd1);
    ls = idle || wrap;
    lm = turn && a_mode[2];
    if (ls) begin
      m_cnt = 0; m_down = 0;
    end else if (turn) m_down = 1;
    else if (m_down) m_cnt = m_cnt - 16'd1;
    else m_cnt = m_cnt + 16'd1;
    if (ls) begin
      a_per = sh_per; a_mode = sh_mode;
    end
    if (ls || lm) for (int i = 0; i < 4; i++) a_duty[i] = sh_duty[i];
    if (we) begin
      if (a == 3'd0) sh_per = d;
      else if (a == 3'd1) sh_mode = d[2:0];
      else if (a >= 3'd4) sh_duty[a-3'd4] = d;
    end
  endtask

  function automatic string mode_tag();
    if (a_per == 0) return "R1";
    if (a_mode[0] && a_mode[2]) return "R8";
    if (a_mode[1]) return "R5";
    if (a_mode[0]) return "R3";
    return "R4";
  endfunction

  // one cycle: check current outputs, drive inputs, advance model
  task automatic tick(bit we, logic [2:0] a, logic [15:0] d);
    logic [4:0] e;
    e = model_out();
    chk(mode_tag(), {sync_pulse, pwm_out}, e);
    for (int i = 0; i < 4; i++) hi_cnt[i] += pwm_out[i];
    sync_cnt += sync_pulse;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(we, a, d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    tick(1'b1, a, d);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) hi_cnt[i] = 0;
    sync_cnt = 0;
  endtask

  task automatic wait_sync();
    int guard = 0;
    while (sync_pulse !== 1'b1 && guard < 1000) begin
      tick(0, 0, 0);
      guard++;
    end
  endtask

  task automatic sync_align();
    wait_sync();
    tick(0, 0, 0);
    wait_sync();
    clear_counts();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nvec++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [2:0] ra;
    logic [15:0] rd;
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    sh_per = 0; a_per = 0; sh_mode = 0; a_mode = 0; m_cnt = 0; m_down = 0;
    for (int i = 0; i < 4; i++) begin sh_duty[i] = 0; a_duty[i] = 0; end
    clear_counts();
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset", {sync_pulse, pwm_out}, 0);
    rst_n = 1;
    @(negedge clk);
    run(3);
    chk("R1 idle", {sync_pulse, pwm_out}, 0);

    // R4, R6, R2: edge-aligned, non-paired, P=5, duties 0,2,5,7
    wr(3'd1, 16'h0);
    wr(3'd4, 16'd0); wr(3'd5, 16'd2); wr(3'd6, 16'd5); wr(3'd7, 16'd7);
    wr(3'd0, 16'd5);
    sync_align();
    run(5);
    chk("R6 duty0 low", hi_cnt[0], 0);
    chk("R4 duty2", hi_cnt[1], 2);
    chk("R6 duty=P high", hi_cnt[2], 5);
    chk("R6 duty>P high", hi_cnt[3], 5);
    chk("R2 sync per P cycles", sync_cnt, 1);
    chk("R9 sync at start", sync_pulse, 1);

    // R3, R5: center-aligned, paired, P=4, d0=1 d2=3, d1/d3 ignored
    wr(3'd1, 16'b011);
    wr(3'd4, 16'd1); wr(3'd5, 16'd9); wr(3'd6, 16'd3); wr(3'd7, 16'd0);
    wr(3'd0, 16'd4);
    sync_align();
    run(8);
    chk("R3 center 2D high", hi_cnt[0], 2);
    chk("R5 complement 1", hi_cnt[1], 6);
    chk("R3 center d=3", hi_cnt[2], 6);
    chk("R5 complement 3", hi_cnt[3], 2);
    chk("R3 period 2P", sync_cnt, 1);
    chk("R9 next start", sync_pulse, 1);

    // R7: center single update, P=6, d0=2 then write 4 mid-period
    wr(3'd1, 16'b001);
    wr(3'd4, 16'd2);
    wr(3'd0, 16'd6);
    sync_align();
    wr(3'd4, 16'd4);
    run(11);
    chk("R7 held until start", hi_cnt[0], 4);
    clear_counts();
    run(12);
    chk("R7 new duty at start", hi_cnt[0], 8);

    // R8: double update, falling half takes the new duty
    wr(3'd1, 16'b101);
    wr(3'd4, 16'd2);
    sync_align();
    wr(3'd4, 16'd4);
    run(11);
    chk("R8 asymmetric 2+4", hi_cnt[0], 6);
    clear_counts();
    run(12);
    chk("R8 full new duty", hi_cnt[0], 8);

    // R10: period write mid-period does not shorten it
    wr(3'd1, 16'b000);
    wr(3'd0, 16'd8);
    sync_align();
    wr(3'd0, 16'd3);
    run(7);
    chk("R10 old period kept", sync_pulse, 1);
    chk("R10 one sync", sync_cnt, 1);
    clear_counts();
    run(3);
    chk("R10 new period", sync_pulse, 1);

    // R1: period 0 returns to idle
    wr(3'd0, 16'd0);
    run(6);
    chk("R1 idle again", {sync_pulse, pwm_out}, 0);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        ra = 3'($urandom_range(0, 7));
        if (ra == 3'd0) rd = 16'($urandom_range(0, 12));
        else if (ra == 3'd1) rd = 16'($urandom_range(0, 7));
        else rd = 16'($urandom_range(0, 14));
        tick(1'b1, ra, rd);
      end else begin
        tick(0, 0, 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule